// File: doc/BRIEF.md
# Dual-Convention Stack Push/Pop Unit

This block keeps a 16-bit stack pointer and moves bytes or two-byte words between a requester and a byte-wide memory. A requester raises a push or a pop request for one cycle, with a width select and write data. The unit then drives the memory port for one cycle per byte. It returns read data with a single-cycle completion pulse, and it updates the stack pointer. A convention input, sampled with the request, selects how the pointer relates to the stack contents.

In next-free mode the pointer names the empty slot below the top of the stack. In last-used mode the pointer names the byte pushed most recently. Words are big-endian: the high byte sits at the lower address and is always moved in the first memory cycle. The memory port is assumed to return read data in the same cycle as the address. The pointer can also be loaded directly while the unit is idle.

The controller is a four-state machine:
- IDLE waits for a request.
- XFER_A moves the first byte, or the only byte.
- XFER_B moves the second byte of a word.
- FIN raises the completion pulse.

Transitions:
- IDLE to XFER_A on an accepted request.
- XFER_A to XFER_B for a word, or to FIN for a byte.
- XFER_B to FIN.
- FIN to IDLE.

Top module: `stack_unit`

## Requirements
- R1: After reset, sp equals the RESET_SP parameter, and busy, done and mem_we are all 0.
- R2: With conv_last=0 (next-free), a byte push writes the byte at SP and leaves SP at SP-1.
- R3: With conv_last=0, a word push writes the high byte at SP-1 and the low byte at SP, and leaves SP at SP-2.
- R4: With conv_last=0, a byte pop reads SP+1 and leaves SP at SP+1. A word pop reads its high byte at SP+1 and its low byte at SP+2, and leaves SP at SP+2.
- R5: With conv_last=1 (last-used), a byte push writes at SP-1, and a word push writes its high byte at SP-2 and its low byte at SP-1. In both cases the final SP equals the lowest address written.
- R6: With conv_last=1, a byte pop reads SP and leaves SP at SP+1. A word pop reads its high byte at SP and its low byte at SP+1, and leaves SP at SP+2.
- R7: req_word=1 selects a word. Bits 15:8 of wr_data and rd_data are the high byte, and that byte travels in the first memory cycle at the lower address. A byte push uses wr_data[7:0]. A byte pop returns the byte in rd_data[7:0] with rd_data[15:8]=0.
- R8: The first memory cycle is the cycle after the request edge. A word uses two consecutive memory cycles. done is high for exactly one cycle, the cycle after the last memory cycle, and sp shows its new value in that same cycle.
- R9: All stack pointer and address arithmetic wraps modulo 2^16.
- R10: While busy is high, push, pop and load requests are ignored.
- R11: When idle, ld_en=1 loads ld_val into sp at the next edge, and any push or pop request in that cycle is dropped.
- R12: When idle, with no load, and push and pop are both requested, the push is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_last | input | 1 | Convention select: 0 next-free, 1 last-used |
| req_push | input | 1 | Push request |
| req_pop | input | 1 | Pop request |
| req_word | input | 1 | 1 word, 0 byte |
| wr_data | input | 16 | Push data |
| ld_en | input | 1 | Direct stack pointer load |
| ld_val | input | 16 | Value for the load |
| rd_data | output | 16 | Pop result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| sp | output | 16 | Stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the address cycle |

## Verification
The bench keeps SP_W=16 and BYTE_W=8, and sets RESET_SP to 16'h0200. With a full 16-bit pointer, the wrap points at 0xFFFF and 0x0000 are reached through the load port. A word push from 0x0000 and a word pop from 0xFFFF then split across the boundary. The bench's 1024-byte memory aliases addresses on their low ten bits. This lets random runs, which mix the two conventions and let the pointer drift, still check every pop against the bytes actually stored.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER_A = 2'd1,
        ST_XFER_B = 2'd2,
        ST_FIN    = 2'd3
    } stk_state_e;

    typedef enum logic {
        CONV_NEXT_FREE = 1'b0,
        CONV_LAST_USED = 1'b1
    } stk_conv_e;
endpackage

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
    import stk_pkg::*;
#(
    parameter int SP_W = 16
) (
    input  logic [SP_W-1:0] sp_cur,
    input  logic            conv_last,
    input  logic            is_push,
    input  logic            is_word,
    output logic [SP_W-1:0] first_addr,
    output logic [SP_W-1:0] next_sp
);
    localparam logic [SP_W-1:0] STEP1 = SP_W'(1);
    localparam logic [SP_W-1:0] STEP2 = SP_W'(2);

    stk_conv_e        conv;
    logic [SP_W-1:0]  delta;

    always_comb begin
        conv  = stk_conv_e'(conv_last);
        delta = is_word ? STEP2 : STEP1;
        if (is_push) begin
            next_sp = sp_cur - delta;
            if (conv == CONV_LAST_USED) begin
                first_addr = sp_cur - delta;
            end else begin
                first_addr = is_word ? (sp_cur - STEP1) : sp_cur;
            end
        end else begin
            next_sp = sp_cur + delta;
            if (conv == CONV_LAST_USED) begin
                first_addr = sp_cur;
            end else begin
                first_addr = sp_cur + STEP1;
            end
        end
    end
endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
    parameter int              SP_W     = 16,
    parameter logic [SP_W-1:0] RESET_SP = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_take,
    input  logic [SP_W-1:0] ld_val,
    input  logic            upd_take,
    input  logic [SP_W-1:0] upd_val,
    output logic [SP_W-1:0] sp_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= RESET_SP;
        end else if (ld_take) begin
            sp_q <= ld_val;
        end else if (upd_take) begin
            sp_q <= upd_val;
        end
    end

    // R10
    sp_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_take && upd_take));

    // R11
    sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_take |=> (sp_q == $past(ld_val)));

    // R10
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_take && !upd_take) |=> $stable(sp_q));
endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_push,
    input  logic                req_pop,
    input  logic                req_word,
    input  logic                ld_en,
    input  logic [2*BYTE_W-1:0] wr_data,
    input  logic [SP_W-1:0]     calc_first,
    input  logic [SP_W-1:0]     calc_next,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                done,
    output logic                ld_take,
    output logic                upd_take,
    output logic [SP_W-1:0]     upd_val,
    output logic [SP_W-1:0]     mem_addr,
    output logic                mem_we,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic [2*BYTE_W-1:0] rd_data
);
    localparam int              WORD_W = 2 * BYTE_W;
    localparam logic [SP_W-1:0] STEP1  = SP_W'(1);

    stk_state_e          state_q, state_d;
    logic                accept;
    logic                op_push_q, op_word_q;
    logic [SP_W-1:0]     addr_q, nsp_q;
    logic [WORD_W-1:0]   wdat_q, rd_q;
    logic [BYTE_W-1:0]   hi_q;

    assign accept = (state_q == ST_IDLE) && !ld_en && (req_push || req_pop);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_XFER_A;
            ST_XFER_A: state_d = op_word_q ? ST_XFER_B : ST_FIN;
            ST_XFER_B: state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_push_q <= 1'b0;
            op_word_q <= 1'b0;
            addr_q    <= '0;
            nsp_q     <= '0;
            wdat_q    <= '0;
            rd_q      <= '0;
            hi_q      <= '0;
        end else begin
            if (accept) begin
                op_push_q <= req_push;
                op_word_q <= req_word;
                addr_q    <= calc_first;
                nsp_q     <= calc_next;
                wdat_q    <= wr_data;
            end
            if (state_q == ST_XFER_A && !op_push_q) begin
                if (op_word_q) begin
                    hi_q <= mem_rdata;
                end else begin
                    rd_q <= {{BYTE_W{1'b0}}, mem_rdata};
                end
            end
            if (state_q == ST_XFER_B && !op_push_q) begin
                rd_q <= {hi_q, mem_rdata};
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FIN);
        ld_take   = (state_q == ST_IDLE) && ld_en;
        upd_take  = 1'b0;
        upd_val   = nsp_q;
        mem_addr  = addr_q;
        mem_we    = 1'b0;
        mem_wdata = wdat_q[BYTE_W-1:0];
        rd_data   = rd_q;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_XFER_A: begin
                mem_we    = op_push_q;
                mem_wdata = op_word_q ? wdat_q[WORD_W-1:BYTE_W] : wdat_q[BYTE_W-1:0];
                upd_take  = !op_word_q;
            end
            ST_XFER_B: begin
                mem_addr  = addr_q + STEP1;
                mem_we    = op_push_q;
                mem_wdata = wdat_q[BYTE_W-1:0];
                upd_take  = 1'b1;
            end
            ST_FIN: begin
            end
        endcase
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    word_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER_B) |-> (mem_addr == $past(mem_addr) + STEP1));

    // R10
    busy_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER_A || state_q == ST_XFER_B) |=> ($stable(addr_q) && $stable(wdat_q)));

    // R8
    fin_follows_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |-> ($past(state_q) == ST_XFER_B || $past(state_q) == ST_XFER_A));
endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
    parameter int              SP_W     = 16,
    parameter int              BYTE_W   = 8,
    parameter logic [SP_W-1:0] RESET_SP = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_last,
    input  logic                req_push,
    input  logic                req_pop,
    input  logic                req_word,
    input  logic [2*BYTE_W-1:0] wr_data,
    input  logic                ld_en,
    input  logic [SP_W-1:0]     ld_val,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic                done,
    output logic                busy,
    output logic [SP_W-1:0]     sp,
    output logic [SP_W-1:0]     mem_addr,
    output logic                mem_we,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata
);
    logic [SP_W-1:0] calc_first, calc_next, upd_val;
    logic            ld_take, upd_take;

    stk_addr_gen #(.SP_W(SP_W)) u_addr (
        .sp_cur     (sp),
        .conv_last  (conv_last),
        .is_push    (req_push),
        .is_word    (req_word),
        .first_addr (calc_first),
        .next_sp    (calc_next)
    );

    stk_fsm #(.SP_W(SP_W), .BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_push   (req_push),
        .req_pop    (req_pop),
        .req_word   (req_word),
        .ld_en      (ld_en),
        .wr_data    (wr_data),
        .calc_first (calc_first),
        .calc_next  (calc_next),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .ld_take    (ld_take),
        .upd_take   (upd_take),
        .upd_val    (upd_val),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .rd_data    (rd_data)
    );

    stk_sp_reg #(.SP_W(SP_W), .RESET_SP(RESET_SP)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_take  (ld_take),
        .ld_val   (ld_val),
        .upd_take (upd_take),
        .upd_val  (upd_val),
        .sp_q     (sp)
    );

    // R12
    push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ld_en && req_push && req_pop) |=> mem_we);

    // R8
    sp_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (sp != $past(sp)));
endmodule

// File: tb/stack_unit_test.sv
module stack_unit_test;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] RST_SP     = 16'h0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_last = 1'b0, req_push = 1'b0, req_pop = 1'b0, req_word = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_val = '0;
    logic [15:0] rd_data, sp, mem_addr;
    logic        done, busy, mem_we;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  bmem [0:1023];
    logic [15:0] ref_sp;
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_unit #(.SP_W(16), .BYTE_W(8), .RESET_SP(RST_SP)) uut (
        .clk(clk), .rst_n(rst_n), .conv_last(conv_last), .req_push(req_push),
        .req_pop(req_pop), .req_word(req_word), .wr_data(wr_data), .ld_en(ld_en),
        .ld_val(ld_val), .rd_data(rd_data), .done(done), .busy(busy), .sp(sp),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
    assign mem_rdata = bmem[mem_addr[9:0]];

    function automatic logic [15:0] exp_first(bit push, bit word, bit lu, logic [15:0] s);
        if (push) begin
            if (lu) return word ? s - 16'd2 : s - 16'd1;
            return word ? s - 16'd1 : s;
        end
        return lu ? s : s + 16'd1;
    endfunction

    function automatic logic [15:0] exp_next(bit push, bit word, logic [15:0] s);
        if (push) return word ? s - 16'd2 : s - 16'd1;
        return word ? s + 16'd2 : s + 16'd1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(bit push, bit word, bit lu, logic [15:0] data, bit inject, bit both);
        logic [15:0] a0, a1, nsp, exp_rd;
        string rtag;
        @(negedge clk);
        a0  = exp_first(push, word, lu, ref_sp);
        a1  = a0 + 16'd1;
        nsp = exp_next(push, word, ref_sp);
        exp_rd = word ? {bmem[a0[9:0]], bmem[a1[9:0]]} : {8'h00, bmem[a0[9:0]]};
        if (push) rtag = lu ? "R5" : (word ? "R3" : "R2");
        else      rtag = lu ? "R6" : "R4";
        conv_last = lu; req_push = push; req_pop = !push || both;
        req_word = word; wr_data = data;
        @(negedge clk);
        req_push = 0; req_pop = 0; req_word = 0;
        if (inject) begin
            req_push = 1; req_pop = 1; ld_en = 1; ld_val = 16'h5A5A;
        end
        chk({rtag, " first addr"}, 32'(mem_addr), 32'(a0));
        chk({rtag, " first we"}, 32'(mem_we), 32'(push));
        if (push) chk("R7 first wdata", 32'(mem_wdata), 32'(word ? data[15:8] : data[7:0]));
        chk("R8 busy in xfer", 32'(busy), 32'd1);
        @(negedge clk);
        req_push = 0; req_pop = 0; ld_en = 0;
        if (word) begin
            chk({rtag, " second addr"}, 32'(mem_addr), 32'(a1));
            chk({rtag, " second we"}, 32'(mem_we), 32'(push));
            if (push) chk("R7 low wdata", 32'(mem_wdata), 32'(data[7:0]));
            chk("R8 no early done", 32'(done), 32'd0);
            @(negedge clk);
        end
        chk("R8 done pulse", 32'(done), 32'd1);
        chk({rtag, " new sp"}, 32'(sp), 32'(nsp));
        if (!push) chk("R7 rd_data", 32'(rd_data), 32'(exp_rd));
        @(negedge clk);
        chk("R8 done one cycle", 32'(done), 32'd0);
        chk(inject ? "R10 idle after op" : "R8 idle after op", 32'(busy), 32'd0);
        if (inject) chk("R10 load ignored", 32'(sp), 32'(nsp));
        ref_sp = nsp;
    endtask

    task automatic do_load(logic [15:0] v);
        @(negedge clk);
        ld_en = 1; ld_val = v; req_push = 1; req_word = 1;
        @(negedge clk);
        ld_en = 0; req_push = 0; req_word = 0;
        chk("R11 sp loaded", 32'(sp), 32'(v));
        chk("R11 request dropped busy", 32'(busy), 32'd0);
        chk("R11 request dropped we", 32'(mem_we), 32'd0);
        ref_sp = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog R8 actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
        void'($urandom(32'd4711));
        ref_sp = RST_SP;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset sp", 32'(sp), 32'(RST_SP));
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);
        chk("R1 reset we", 32'(mem_we), 32'd0);

        // next-free directed
        run_op(1, 0, 0, 16'h00AB, 0, 0);
        run_op(1, 1, 0, 16'h1234, 0, 0);
        run_op(0, 1, 0, 16'h0000, 0, 0);
        chk("R4 word pop value", 32'(rd_data), 32'h1234);
        run_op(0, 0, 0, 16'h0000, 0, 0);
        chk("R4 byte pop value", 32'(rd_data), 32'h00AB);
        chk("R4 sp restored", 32'(sp), 32'(RST_SP));

        // last-used directed
        run_op(1, 0, 1, 16'h00C3, 0, 0);
        run_op(1, 1, 1, 16'hA55A, 0, 0);
        chk("R5 sp at last written", 32'(sp), 32'(RST_SP - 16'd3));
        run_op(0, 1, 1, 16'h0000, 0, 0);
        chk("R6 word pop value", 32'(rd_data), 32'hA55A);
        run_op(0, 0, 1, 16'h0000, 0, 0);
        chk("R6 byte pop value", 32'(rd_data), 32'h00C3);

        // wrap cases
        do_load(16'h0000);
        run_op(1, 1, 0, 16'hBEEF, 0, 0);
        chk("R9 sp wrapped", 32'(sp), 32'hFFFE);
        chk("R9 high byte at FFFF", 32'(bmem[10'h3FF]), 32'hBE);
        chk("R9 low byte at 0000", 32'(bmem[10'h000]), 32'hEF);
        do_load(16'hFFFF);
        run_op(0, 1, 1, 16'h0000, 0, 0);
        chk("R9 pop across wrap", 32'(rd_data), 32'hBEEF);
        chk("R9 sp after wrap pop", 32'(sp), 32'h0001);

        // busy and priority
        do_load(16'h0300);
        run_op(1, 1, 0, 16'h7788, 1, 0);
        run_op(1, 0, 1, 16'h0066, 0, 1);
        chk("R12 push taken", 32'(bmem[10'(16'h02FE - 16'd1)]), 32'h66);
        run_op(0, 0, 1, 16'h0000, 1, 0);
        chk("R10 pop value", 32'(rd_data), 32'h0066);

        // random mix
        do_load(16'h0200);
        for (int n = 0; n < 200; n++) begin
            bit p, w, l;
            p = 1'($urandom);
            w = 1'($urandom);
            l = 1'($urandom);
            run_op(p, w, l, 16'($urandom), (($urandom % 8) == 0), 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule